// File: doc/BRIEF.md
# Port Instruction Sequencer with Requeue

This block is the control engine that sits at one port of a dataflow switch fabric. Instruction words of 37 bits are handed to it over a valid/ready handshake and held in an internal queue. The instruction at the head of the queue runs alone. It can wait for an arriving item on the data/token input and capture it into a data latch or a path latch. It can also emit a 49-bit packet made of a 12-bit path and a 37-bit data word. Each instruction retires only once every handshake it asked for has completed.

Besides ordinary work instructions there are four queue-level forms. A literal loads an immediate into the data latch. A kill drops a number of later instructions. A clog freezes execution until an unclog is offered on the instruction input. A per-instruction count lets a work instruction run again: after it retires it rewrites itself at the tail of its own queue with the count lowered by one. When the count field holds its maximum value the instruction is standing and is written back unchanged every time.

Top module: `inst_sequencer`

## Requirements
- R1: A synchronous active-high reset empties the queue and clears the data latch, the path latch, the kill counter and the clogged state. After reset, ins_ready is 1 and pkt_valid and din_ready are 0.
- R2: A literal word (bits 36:35 = 01) loads bits 34:0, zero-extended, into the data latch. A later send (work form, bits 36:35 = 00, bit 31 set) emits pkt_word with the path in bits 48:37, the data latch in bits 36:0, and pkt_tok = 0.
- R3: A work word with bit 28 set takes bits 27:16 as the path of its own packet and leaves that path in the path latch for later sends.
- R4: In a work word, bit 33 set waits for one din item. If bit 32 is also set, the item is captured into the data latch, or into the path latch as {0, din_word[36:26]} when bit 15 is set. With bit 32 clear the item is consumed and both latches stay unchanged.
- R5: Bit 30 set with bit 31 clear emits a token: pkt_tok = 1 and a zero data field. pkt_last is 1 exactly when bits 30 and 29 are both set.
- R6: Bit 34 waits for any din item. A packet is not offered before the instruction's input has been accepted. While pkt_ready is low, pkt_valid stays high, pkt_word is unchanged and the instruction does not retire.
- R7: A work word with count field c (bits 6:0) below 127 executes c+1 times through requeueing. With c = 127 it executes for ever.
- R8: Queued and requeued instructions execute in queue order. In a cycle where a retiring instruction writes itself back, ins_ready is 0.
- R9: A kill word (bits 36:35 = 10) with count n in bits 6:0 discards the next n queued instructions. These cause no packet and no input acceptance.
- R10: A clog word (bits 36:34 = 110) stops all execution until an unclog word (bits 36:34 = 111) is offered on the instruction input. That unclog is taken at once and does not enter the queue. An unclog that reaches the head while nothing is clogged has no effect.
- R11: A work word with all control bits clear and count 0 retires without touching either latch or the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction word offered |
| ins_ready | output | 1 | Instruction word accepted this cycle |
| ins_word | input | 37 | Instruction word |
| din_valid | input | 1 | Arriving datum or token offered |
| din_ready | output | 1 | Head instruction accepts the arriving item |
| din_word | input | 37 | Arriving datum (token payload is ignored) |
| pkt_valid | output | 1 | Packet offered |
| pkt_ready | input | 1 | Packet taken by the fabric |
| pkt_word | output | 49 | Path (48:37) and data (36:0) |
| pkt_tok | output | 1 | Packet is a token |
| pkt_last | output | 1 | Token is a notify-last |

## Verification
Two pairs of functions can meet in one cycle. The first pair is the tail write of a requeueing instruction and a new word offered on the instruction input. A standing instruction that writes itself back every cycle provokes this; ins_ready must then stay low, and two interleaved counted sends must come out in strict alternation. The second pair is the release of a clog and the arrival of the unclog on the input while the queue is still full of waiting work. This is judged by the fact that nothing leaves before the unclog, and that the queued work then drains in its original order.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;
    localparam int WORD_W = 37;
    localparam int PATH_W = 12;
    localparam int PKT_W  = PATH_W + WORD_W;
    localparam int IMM_W  = WORD_W - 2;

    typedef enum logic [1:0] {
        F_WORK = 2'b00,
        F_LIT  = 2'b01,
        F_KILL = 2'b10,
        F_QCTL = 2'b11
    } form_e;

    typedef struct packed {
        form_e             form;
        logic              unclog;
        logic              ti;
        logic              di;
        logic              dc;
        logic              dout;
        logic              tout;
        logic              ig;
        logic              lp;
        logic              lpd;
        logic [PATH_W-1:0] ipath;
        logic [IMM_W-1:0]  imm;
    } dec_t;
endpackage

// File: rtl/seq_decode.sv
`timescale 1ns/1ps
module seq_decode
    import seq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);
    always_comb begin
        dec.form   = form_e'(word[36:35]);
        dec.unclog = word[34];
        dec.ti     = word[34];
        dec.di     = word[33];
        dec.dc     = word[32];
        dec.dout   = word[31];
        dec.tout   = word[30];
        dec.ig     = word[29];
        dec.lp     = word[28];
        dec.ipath  = word[27:16];
        dec.lpd    = word[15];
        dec.imm    = word[IMM_W-1:0];
    end
endmodule

// File: rtl/seq_queue.sv
`timescale 1ns/1ps
module seq_queue #(
    parameter int DEPTH = 8,
    parameter int W     = 37
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } qst_t;

    qst_t qs_d, qs_q;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        qs_d = qs_q;
        if (push) qs_d.wr = (qs_q.wr == LAST) ? '0 : qs_q.wr + 1'b1;
        if (pop)  qs_d.rd = (qs_q.rd == LAST) ? '0 : qs_q.rd + 1'b1;
        qs_d.cnt = qs_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (rst) qs_q <= '0;
        else     qs_q <= qs_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[qs_q.wr] <= wdata;
    end

    assign rdata = mem[qs_q.rd];
    assign empty = (qs_q.cnt == '0);
    assign full  = (qs_q.cnt == FULL);
endmodule

// File: rtl/inst_sequencer.sv
`timescale 1ns/1ps
module inst_sequencer
    import seq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [WORD_W-1:0] ins_word,
    input  logic              din_valid,
    output logic              din_ready,
    input  logic [WORD_W-1:0] din_word,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    output logic [PKT_W-1:0]  pkt_word,
    output logic              pkt_tok,
    output logic              pkt_last
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic              got_in;
        logic [CNT_W-1:0]  kill_left;
        logic              clogged;
        logic [WORD_W-1:0] data;
        logic [PATH_W-1:0] path;
    } st_t;

    st_t st_d, st_q;

    logic [WORD_W-1:0] head;
    logic              q_empty, q_full, q_pop, q_push;
    logic              rq_push;
    logic [WORD_W-1:0] rq_word, q_wdata;
    logic              unclog_take, ins_is_unclog;
    logic              need_in, need_out, in_fire, pkt_fire, done;
    logic [CNT_W-1:0]  head_cnt;
    logic [PATH_W-1:0] out_path;
    logic              clog_st, kill_busy;
    dec_t              hd;

    seq_decode u_dec (.word(head), .dec(hd));

    seq_queue #(.DEPTH(DEPTH), .W(WORD_W)) u_q (
        .clk(clk), .rst(rst),
        .push(q_push), .wdata(q_wdata),
        .pop(q_pop), .rdata(head),
        .empty(q_empty), .full(q_full)
    );

    assign head_cnt      = head[CNT_W-1:0];
    assign ins_is_unclog = (ins_word[36:34] == 3'b111);

    always_comb begin
        st_d        = st_q;
        q_pop       = 1'b0;
        rq_push     = 1'b0;
        rq_word     = head;
        din_ready   = 1'b0;
        pkt_valid   = 1'b0;
        pkt_word    = '0;
        pkt_tok     = 1'b0;
        pkt_last    = 1'b0;
        need_in     = 1'b0;
        need_out    = 1'b0;
        in_fire     = 1'b0;
        pkt_fire    = 1'b0;
        done        = 1'b0;
        out_path    = st_q.path;
        unclog_take = st_q.clogged && ins_valid && ins_is_unclog;

        if (unclog_take) st_d.clogged = 1'b0;

        if (st_q.kill_left != '0) begin
            if (!q_empty) begin
                q_pop          = 1'b1;
                st_d.kill_left = st_q.kill_left - 1'b1;
            end
        end else if (!st_q.clogged && !q_empty) begin
            unique case (hd.form)
                F_LIT: begin
                    st_d.data = {2'b00, hd.imm};
                    q_pop     = 1'b1;
                end
                F_KILL: begin
                    st_d.kill_left = head_cnt;
                    q_pop          = 1'b1;
                end
                F_QCTL: begin
                    if (!hd.unclog) st_d.clogged = 1'b1;
                    q_pop = 1'b1;
                end
                default: begin
                    need_in   = hd.ti | hd.di;
                    need_out  = hd.dout | hd.tout;
                    din_ready = need_in && !st_q.got_in;
                    in_fire   = din_valid && din_ready;
                    if (in_fire) begin
                        st_d.got_in = 1'b1;
                        if (hd.di && hd.dc) begin
                            if (hd.lpd) st_d.path = {1'b0, din_word[WORD_W-1:WORD_W-PATH_W+1]};
                            else        st_d.data = din_word;
                        end
                    end
                    out_path  = hd.lp ? hd.ipath : st_q.path;
                    pkt_valid = need_out && (!need_in || st_q.got_in);
                    pkt_word  = {out_path, hd.dout ? st_q.data : {WORD_W{1'b0}}};
                    pkt_tok   = pkt_valid && !hd.dout;
                    pkt_last  = pkt_valid && hd.tout && hd.ig;
                    pkt_fire  = pkt_valid && pkt_ready;
                    done = (!need_in || st_q.got_in || in_fire) && (!need_out || pkt_fire);
                    if (done) begin
                        q_pop       = 1'b1;
                        st_d.got_in = 1'b0;
                        if (hd.lp) st_d.path = hd.ipath;
                        if (head_cnt == CNT_MAX) begin
                            rq_push = 1'b1;
                        end else if (head_cnt != '0) begin
                            rq_push = 1'b1;
                            rq_word = {head[WORD_W-1:CNT_W], head_cnt - 1'b1};
                        end
                    end
                end
            endcase
        end

        if (unclog_take) ins_ready = 1'b1;
        else             ins_ready = !q_full && !rq_push;

        q_push  = rq_push || (ins_valid && ins_ready && !unclog_take);
        q_wdata = rq_push ? rq_word : ins_word;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign clog_st   = st_q.clogged;
    assign kill_busy = (st_q.kill_left != '0);
endmodule

// File: rtl/seq_checker.sv
`timescale 1ns/1ps
module seq_checker
    import seq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pkt_valid,
    input logic             pkt_ready,
    input logic [PKT_W-1:0] pkt_word,
    input logic             ins_ready,
    input logic             din_ready,
    input logic             rq_push,
    input logic             clog_st,
    input logic             kill_busy
);
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> !pkt_valid && !din_ready && !clog_st && !kill_busy);

    a_r6_pkt_hold: assert property (@(posedge clk) disable iff (rst)
        pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_word));

    a_r8_requeue_slot: assert property (@(posedge clk) disable iff (rst)
        rq_push |-> !ins_ready);

    a_r9_kill_quiet: assert property (@(posedge clk) disable iff (rst)
        kill_busy |-> !pkt_valid && !din_ready);

    a_r10_clog_quiet: assert property (@(posedge clk) disable iff (rst)
        clog_st |-> !pkt_valid && !din_ready);
endmodule

bind inst_sequencer seq_checker u_chk (
    .clk(clk), .rst(rst),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_word(pkt_word),
    .ins_ready(ins_ready), .din_ready(din_ready),
    .rq_push(rq_push), .clog_st(clog_st), .kill_busy(kill_busy)
);

// File: tb/inst_sequencer_tb.sv
`timescale 1ns/1ps
module inst_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid = 1'b0, din_valid = 1'b0, pkt_ready = 1'b1;
    logic [36:0] ins_word = '0, din_word = '0;
    logic        ins_ready, din_ready, pkt_valid, pkt_tok, pkt_last;
    logic [48:0] pkt_word;

    always #2 clk = ~clk;

    inst_sequencer #(.DEPTH(8), .CNT_W(7)) u_dut (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_word(ins_word),
        .din_valid(din_valid), .din_ready(din_ready), .din_word(din_word),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_word(pkt_word),
        .pkt_tok(pkt_tok), .pkt_last(pkt_last)
    );

    int total = 0, bad = 0, npk = 0, cyc = 0;
    logic [48:0] pw [256];
    logic        ptk [256];
    logic        plst [256];

    always begin
        @(negedge clk);
        #1;
        if (!rst && pkt_valid && pkt_ready) begin
            if (npk < 256) begin
                pw[npk] = pkt_word; ptk[npk] = pkt_tok; plst[npk] = pkt_last;
            end
            npk++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            total++; bad++;
            $display("FAIL watchdog: act=%0d exp<%0d cycles", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [36:0] f_work(input bit ti, di, dc, dout, tout, ig, lp,
                                           input logic [11:0] p, input bit lpd, input logic [6:0] c);
        return {2'b00, ti, di, dc, dout, tout, ig, lp, p, lpd, 8'b0, c};
    endfunction
    function automatic logic [36:0] f_lit(input logic [34:0] v);
        return {2'b01, v};
    endfunction
    function automatic logic [36:0] f_kill(input logic [6:0] n);
        return {2'b10, 28'b0, n};
    endfunction
    localparam logic [36:0] W_CLOG   = {3'b110, 34'b0};
    localparam logic [36:0] W_UNCLOG = {3'b111, 34'b0};
    localparam logic [36:0] W_SEND   = {2'b00, 7'b0001000, 12'h0, 1'b0, 8'b0, 7'd0};

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1; ins_valid = 1'b0; din_valid = 1'b0; pkt_ready = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0; npk = 0;
        #1;
    endtask

    task automatic push(input logic [36:0] w);
        @(negedge clk);
        ins_valid = 1'b1; ins_word = w;
        #1;
        while (!ins_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        ins_valid = 1'b0;
    endtask

    task automatic give(input logic [36:0] d);
        @(negedge clk);
        din_valid = 1'b1; din_word = d;
        #1;
        while (!din_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        din_valid = 1'b0;
    endtask

    localparam logic [34:0] L1 = 35'h1_2345_6789;
    localparam logic [34:0] L2 = 35'h0_0BAD_F00D;
    localparam logic [36:0] D1 = 37'h1_ABCD_0123;
    localparam logic [36:0] D2 = 37'h1_5A5A_5A5A;
    localparam logic [36:0] D3 = 37'h0_FFFF_FFFF;

    task automatic t_reset;
        do_reset;
        chk(ins_ready == 1'b1, "R1 ins_ready after reset", 64'(ins_ready), 64'd1);
        chk(pkt_valid == 1'b0 && din_ready == 1'b0, "R1 outputs idle after reset",
            64'({pkt_valid, din_ready}), 64'd0);
    endtask

    task automatic t_literal;
        do_reset;
        push(f_lit(L1));
        push(f_work(0,0,0,1,0,0,1,12'hA5C,0,7'd0));
        idle(6);
        chk(npk == 1, "R2 one packet", 64'(npk), 64'd1);
        chk(pw[0] == {12'hA5C, 2'b00, L1}, "R2 literal packet", 64'(pw[0]), 64'({12'hA5C, 2'b00, L1}));
        chk(ptk[0] == 1'b0, "R2 data packet not token", 64'(ptk[0]), 64'd0);
        push(W_SEND);
        idle(6);
        chk(npk == 2 && pw[1][48:37] == 12'hA5C, "R3 path kept in latch", 64'(pw[1][48:37]), 64'h A5C);
    endtask

    task automatic t_capture;
        do_reset;
        push(f_work(0,1,1,0,0,0,0,12'h0,0,7'd0));
        give(D1);
        push(W_SEND);
        idle(6);
        chk(npk == 1 && pw[0] == {12'h0, D1}, "R4 datum captured", 64'(pw[0]), 64'({12'h0, D1}));
        push(f_work(0,1,1,0,0,0,0,12'h0,1,7'd0));
        give(D2);
        push(W_SEND);
        idle(6);
        chk(npk == 2 && pw[1] == {1'b0, D2[36:26], D1}, "R4 path from datum",
            64'(pw[1]), 64'({1'b0, D2[36:26], D1}));
        push(f_work(0,1,0,0,0,0,0,12'h0,0,7'd0));
        give(D3);
        push(W_SEND);
        idle(6);
        chk(npk == 3 && pw[2] == {1'b0, D2[36:26], D1}, "R4 discard leaves latches",
            64'(pw[2]), 64'({1'b0, D2[36:26], D1}));
    endtask

    task automatic t_token;
        do_reset;
        push(f_lit(L2));
        push(f_work(0,0,0,0,1,1,0,12'h0,0,7'd0));
        push(f_work(0,0,0,0,1,0,0,12'h0,0,7'd0));
        idle(6);
        chk(npk == 2, "R5 two tokens", 64'(npk), 64'd2);
        chk(ptk[0] == 1'b1 && pw[0] == 49'h0, "R5 token has zero data", 64'(pw[0]), 64'd0);
        chk(plst[0] == 1'b1 && plst[1] == 1'b0, "R5 notify-last flag", 64'({plst[0], plst[1]}), 64'b10);
    endtask

    task automatic t_stall;
        do_reset;
        @(negedge clk); pkt_ready = 1'b0;
        push(f_lit(L2));
        push(W_SEND);
        idle(5);
        chk(pkt_valid == 1'b1 && npk == 0, "R6 packet held while not ready", 64'(npk), 64'd0);
        @(negedge clk); pkt_ready = 1'b1;
        idle(3);
        chk(npk == 1, "R6 packet leaves after ready", 64'(npk), 64'd1);
        push(f_work(1,0,0,1,0,0,0,12'h0,0,7'd0));
        idle(4);
        chk(din_ready == 1'b1 && pkt_valid == 1'b0, "R6 no packet before input",
            64'({din_ready, pkt_valid}), 64'b10);
        give(D3);
        idle(4);
        chk(npk == 2 && pw[1][36:0] == {2'b00, L2}, "R6 token wait keeps data",
            64'(pw[1][36:0]), 64'({2'b00, L2}));
    endtask

    task automatic t_repeat;
        do_reset;
        push(f_work(0,0,0,1,0,0,1,12'h001,0,7'd2));
        idle(14);
        chk(npk == 3, "R7 count 2 runs three times", 64'(npk), 64'd3);
        do_reset;
        push(f_work(0,0,0,1,0,0,1,12'h007,0,7'd127));
        idle(20);
        chk(npk >= 10, "R7 standing keeps sending", 64'(npk), 64'd10);
        chk(pw[9][48:37] == 12'h007, "R7 standing path", 64'(pw[9][48:37]), 64'h7);
        do_reset;
        push(f_work(0,0,0,0,0,0,0,12'h0,0,7'd127));
        idle(3);
        chk(ins_ready == 1'b0, "R8 requeue blocks input", 64'(ins_ready), 64'd0);
        do_reset;
        chk(ins_ready == 1'b1, "R1 reset clears standing queue", 64'(ins_ready), 64'd1);
    endtask

    task automatic t_order;
        do_reset;
        push(W_CLOG);
        push(f_work(0,0,0,1,0,0,1,12'h111,0,7'd1));
        push(f_work(0,0,0,1,0,0,1,12'h222,0,7'd1));
        idle(4);
        chk(npk == 0, "R10 clog stops execution", 64'(npk), 64'd0);
        push(W_UNCLOG);
        idle(10);
        chk(npk == 4, "R8 four packets", 64'(npk), 64'd4);
        chk({pw[0][48:37], pw[1][48:37], pw[2][48:37], pw[3][48:37]} == 48'h111222111222,
            "R8 requeue order", 64'({pw[0][48:37], pw[1][48:37], pw[2][48:37], pw[3][48:37]}),
            64'h111222111222);
    endtask

    task automatic t_kill;
        do_reset;
        push(f_kill(7'd2));
        push(f_lit(L1));
        push(f_work(0,0,0,1,0,0,1,12'h3C3,0,7'd0));
        push(f_lit(L2));
        push(W_SEND);
        idle(8);
        chk(npk == 1, "R9 killed send emits nothing", 64'(npk), 64'd1);
        chk(pw[0] == {12'h0, 2'b00, L2}, "R9 survivor packet", 64'(pw[0]), 64'({12'h0, 2'b00, L2}));
    endtask

    task automatic t_unclog_nop;
        do_reset;
        push(W_UNCLOG);
        push(f_lit(L1));
        push(W_SEND);
        idle(6);
        chk(npk == 1 && pw[0][36:0] == {2'b00, L1}, "R10 stray unclog harmless",
            64'(pw[0][36:0]), 64'({2'b00, L1}));
        push(37'h0);
        push(W_SEND);
        idle(6);
        chk(npk == 2 && pw[1] == {12'h0, 2'b00, L1}, "R11 nop leaves latches",
            64'(pw[1]), 64'({12'h0, 2'b00, L1}));
    endtask

    initial begin
        t_reset;
        t_literal;
        t_capture;
        t_token;
        t_stall;
        t_repeat;
        t_order;
        t_kill;
        t_unclog_nop;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule